// File: doc/BRIEF.md
# Self-Checking Dual-Port RAM

A synchronous RAM with one write port and one read port on a shared clock. It watches how it is used. The number of usable words (`DEPTH`) is a parameter, and it may be smaller than the `2**ADDR_W` words the address bus can reach. A small written map, with one bit per word, records every word that has taken a write since reset. Three kinds of misuse are caught on the port side:

- a read of the word that is being written in the same cycle;
- any read or write at or above `DEPTH`;
- a read of a word that has never been written.

A misused read returns a fixed poison pattern (`POISON`, default `16'hBAD0`) with `rdata_valid` low. Every misuse, read or write, raises a one-cycle `err_pulse` and sets a sticky flag for its kind.

The model is cycle-accurate, not sub-cycle accurate. Read data is registered and appears one cycle after the read is sampled. The read bus is released to high impedance unless both the active-low chip enable and the active-low output enable are asserted. `rdata_en` shows that state as a 2-state signal for simulators that do not keep Z.

Top module: `chk_dpram`

## Requirements
- R1: A read (`ce_n`=0, `re`=1) of a written word below `DEPTH`, with no collision, sets `rdata` to the stored word and `rdata_valid` to 1 after the next clock edge.
- R2: If `ce_n`=0, `we`=1, `re`=1 and `waddr`=`raddr`, the read returns `POISON` with `rdata_valid`=0 and sets `collision_err`. The write still completes.
- R3: A read with `raddr` >= `DEPTH` returns `POISON` with `rdata_valid`=0 and sets `range_err`.
- R4: A write with `waddr` >= `DEPTH` sets `range_err` and changes no stored word and no written-map bit.
- R5: A read, not colliding, of a word below `DEPTH` that has not been written since reset returns `POISON` with `rdata_valid`=0 and sets `uninit_err`.
- R6: `err_pulse` is 1 in the cycle after an edge that sampled any R2 to R5 violation, and 0 after every other edge.
- R7: `collision_err`, `range_err` and `uninit_err` stay set until `rst_n` goes low.
- R8: `rdata_en` is 1 exactly when `ce_n`=0 and `oe_n`=0, and `rdata` is high impedance whenever `rdata_en` is 0.
- R9: With `ce_n`=1, `we` and `re` have no effect: nothing is written, the read register holds and no violation is reported.
- R10: Without a read, `rdata` and `rdata_valid` keep their last values.
- R11: During and after reset, `rdata_valid`, `err_pulse` and all flags are 0, the read register holds `POISON`, and the written map is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, gates both ports |
| oe_n | input | 1 | Output enable, active low |
| we | input | 1 | Write request |
| waddr | input | ADDR_W | Write address |
| wdata | input | DATA_W | Write data |
| re | input | 1 | Read request |
| raddr | input | ADDR_W | Read address |
| rdata | output | DATA_W | Registered read data, Z when not enabled |
| rdata_en | output | 1 | Read bus is being driven |
| rdata_valid | output | 1 | Last read was legal |
| err_pulse | output | 1 | One-cycle violation indication |
| collision_err | output | 1 | Sticky: same-address read during write |
| range_err | output | 1 | Sticky: access at or above DEPTH |
| uninit_err | output | 1 | Sticky: read of a never-written word |

## Verification
A bit in the written map that was wrongly set or wrongly cleared shows up at the first read of that word, one cycle after the read: a legal read comes back as `POISON` with `uninit_err` set, or an unwritten word reads back as valid data. A corrupted stored word, or a write that went through despite R4 or R9, shows as a data mismatch on the next legal read of that word. A broken guard shows in the same cycle as the read register it feeds, through `rdata_valid`, `err_pulse` and the flags. A reference array with its own valid map is therefore compared after every edge, so a divergence is caught at the first read that can expose it.

// File: rtl/chk_dpram_pkg.sv
package chk_dpram_pkg;
   // one bit per kind of misuse found in a cycle
   typedef struct packed {
      logic collide;
      logic oor;
      logic uninit;
   } viol_t;
endpackage

// File: rtl/chk_dpram_guard.sv
module chk_dpram_guard
   import chk_dpram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DEPTH  = 48
) (
   input  logic              ce_n,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [ADDR_W-1:0] raddr,
   input  logic              rd_written,
   output logic              wr_go,
   output logic              rd_go,
   output logic              rd_bad,
   output viol_t             viol
);
   localparam bit FULL_SPACE = (DEPTH == (1 << ADDR_W));

   logic wr_req, rd_req, wr_oor, rd_oor, same_addr;

   assign wr_req    = we & ~ce_n;
   assign rd_req    = re & ~ce_n;
   assign same_addr = (waddr == raddr);

   // range compare only exists when the depth leaves part of the space unused
   if (FULL_SPACE) begin : g_full
      assign wr_oor = 1'b0;
      assign rd_oor = 1'b0;
   end else begin : g_part
      assign wr_oor = (int'(waddr) >= DEPTH);
      assign rd_oor = (int'(raddr) >= DEPTH);
   end

   always_comb begin
      viol.collide = wr_req & rd_req & same_addr;
      viol.oor     = (wr_req & wr_oor) | (rd_req & rd_oor);
      viol.uninit  = rd_req & ~rd_oor & ~viol.collide & ~rd_written;
   end

   assign wr_go  = wr_req & ~wr_oor;
   assign rd_go  = rd_req;
   assign rd_bad = viol.collide | rd_oor | viol.uninit;
endmodule

// File: rtl/chk_dpram_store.sv
module chk_dpram_store #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 6,
   parameter int DEPTH  = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_go,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rd_word,
   output logic              rd_written
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]  wmap;

   always_ff @(posedge clk) begin
      if (wr_go) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wmap        <= '0;
      else if (wr_go) wmap[waddr] <= 1'b1;
   end

   // out-of-range reads are poisoned downstream; clamp the index here
   logic [ADDR_W-1:0] ridx;
   assign ridx       = (int'(raddr) < DEPTH) ? raddr : '0;
   assign rd_word    = mem[ridx];
   assign rd_written = wmap[ridx];
endmodule

// File: rtl/chk_dpram_outstage.sv
module chk_dpram_outstage
   import chk_dpram_pkg::*;
#(
   parameter int                DATA_W = 16,
   parameter logic [DATA_W-1:0] POISON = 16'hBAD0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              rd_go,
   input  logic              rd_bad,
   input  logic [DATA_W-1:0] rd_word,
   input  viol_t             viol,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_en,
   output logic              rdata_valid,
   output logic              err_pulse,
   output viol_t             sticky
);
   logic [DATA_W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q           <= POISON;
         rdata_valid <= 1'b0;
         err_pulse   <= 1'b0;
         sticky      <= '0;
      end else begin
         err_pulse <= |viol;
         sticky    <= sticky | viol;
         if (rd_go) begin
            q           <= rd_bad ? POISON : rd_word;
            rdata_valid <= ~rd_bad;
         end
      end
   end

   assign rdata_en = ~ce_n & ~oe_n;
   assign rdata    = rdata_en ? q : {DATA_W{1'bz}};
endmodule

// File: rtl/chk_dpram.sv
module chk_dpram
   import chk_dpram_pkg::*;
#(
   parameter int                DATA_W = 16,
   parameter int                ADDR_W = 6,
   parameter int                DEPTH  = 48,
   parameter logic [DATA_W-1:0] POISON = 16'hBAD0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_en,
   output logic              rdata_valid,
   output logic              err_pulse,
   output logic              collision_err,
   output logic              range_err,
   output logic              uninit_err
);
   if (DATA_W < 1) begin : g_bad_width
      $error("chk_dpram: DATA_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
      $error("chk_dpram: ADDR_W out of supported range");
   end
   if (DEPTH < 1 || DEPTH > (1 << ADDR_W)) begin : g_bad_depth
      $error("chk_dpram: DEPTH must lie in 1 .. 2**ADDR_W");
   end

   logic              wr_go, rd_go, rd_bad, rd_written;
   logic [DATA_W-1:0] rd_word;
   viol_t             viol, sticky;

   chk_dpram_guard #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_guard (
      .ce_n(ce_n), .we(we), .re(re), .waddr(waddr), .raddr(raddr),
      .rd_written(rd_written), .wr_go(wr_go), .rd_go(rd_go),
      .rd_bad(rd_bad), .viol(viol)
   );

   chk_dpram_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rd_word(rd_word), .rd_written(rd_written)
   );

   chk_dpram_outstage #(.DATA_W(DATA_W), .POISON(POISON)) u_out (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .rd_go(rd_go),
      .rd_bad(rd_bad), .rd_word(rd_word), .viol(viol), .rdata(rdata),
      .rdata_en(rdata_en), .rdata_valid(rdata_valid), .err_pulse(err_pulse),
      .sticky(sticky)
   );

   assign collision_err = sticky.collide;
   assign range_err     = sticky.oor;
   assign uninit_err    = sticky.uninit;
endmodule

// File: rtl/chk_dpram_sva.sv
module chk_dpram_sva #(
   parameter int ADDR_W = 6,
   parameter int DEPTH  = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we,
   input logic              re,
   input logic [ADDR_W-1:0] waddr,
   input logic [ADDR_W-1:0] raddr,
   input logic              rdata_en,
   input logic              rdata_valid,
   input logic              err_pulse,
   input logic              collision_err,
   input logic              range_err,
   input logic              uninit_err
);
   logic any_viol;
   assign any_viol = !ce_n && ((we && re && waddr == raddr) ||
                               (we && int'(waddr) >= DEPTH) ||
                               (re && int'(raddr) >= DEPTH));

   p_collide_poison_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && we && re && waddr == raddr) |=> (!rdata_valid && collision_err));

   p_read_oor_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && re && int'(raddr) >= DEPTH) |=> (!rdata_valid && range_err));

   p_write_oor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && we && int'(waddr) >= DEPTH) |=> range_err);

   p_pulse_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      any_viol |=> err_pulse);

   p_quiet_chip_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> (!err_pulse && $stable(rdata_valid)));

   p_sticky_coll_r7: assert property (@(posedge clk) disable iff (!rst_n)
      collision_err |=> collision_err);
   p_sticky_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      range_err |=> range_err);
   p_sticky_uninit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      uninit_err |=> uninit_err);

   p_bus_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n) |-> !rdata_en);

   p_hold_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!re) |=> $stable(rdata_valid));
endmodule

bind chk_dpram chk_dpram_sva #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_sva (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we(we), .re(re),
   .waddr(waddr), .raddr(raddr), .rdata_en(rdata_en),
   .rdata_valid(rdata_valid), .err_pulse(err_pulse),
   .collision_err(collision_err), .range_err(range_err),
   .uninit_err(uninit_err)
);

// File: tb/tb_chk_dpram.sv
module tb_chk_dpram;
   localparam int              DW     = 16;
   localparam int              AW     = 6;
   localparam int              DEPTH  = 48;
   localparam int              WORDS  = 1 << AW;
   localparam logic [DW-1:0]   POISON = 16'hBAD0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we = 1'b0, re = 1'b0;
   logic [AW-1:0] waddr = '0, raddr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rdata_en, rdata_valid, err_pulse;
   logic          collision_err, range_err, uninit_err;

   chk_dpram #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DEPTH), .POISON(POISON)) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we(we),
      .waddr(waddr), .wdata(wdata), .re(re), .raddr(raddr), .rdata(rdata),
      .rdata_en(rdata_en), .rdata_valid(rdata_valid), .err_pulse(err_pulse),
      .collision_err(collision_err), .range_err(range_err),
      .uninit_err(uninit_err)
   );

   always #2 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   logic [DW-1:0] ref_mem [WORDS];
   logic          ref_wr  [WORDS];
   logic [DW-1:0] exp_q;
   logic          exp_v, exp_pulse, f_coll, f_rng, f_uni;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] pick_addr();
      if ($urandom_range(0, 3) == 0) return AW'($urandom_range(0, WORDS - 1));
      return AW'($urandom_range(0, 11));
   endfunction

   task automatic check_outputs(string tag_rd, string tag_fl, logic c_n, logic o_n);
      chk(tag_rd, "rdata_valid", 32'(rdata_valid), 32'(exp_v));
      chk("R6", "err_pulse", 32'(err_pulse), 32'(exp_pulse));
      chk(tag_fl, "collision_err", 32'(collision_err), 32'(f_coll));
      chk(tag_fl, "range_err", 32'(range_err), 32'(f_rng));
      chk(tag_fl, "uninit_err", 32'(uninit_err), 32'(f_uni));
      chk("R8", "rdata_en", 32'(rdata_en), 32'(!c_n && !o_n));
      if (!c_n && !o_n) chk(tag_rd, "rdata", 32'(rdata), 32'(exp_q));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we = 1'b0; re = 1'b0;
      for (int i = 0; i < WORDS; i++) ref_wr[i] = 1'b0;
      exp_q = POISON; exp_v = 1'b0; exp_pulse = 1'b0;
      f_coll = 1'b0; f_rng = 1'b0; f_uni = 1'b0;
      #1 check_outputs("R11", "R11", 1'b0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1 check_outputs("R11", "R11", 1'b0, 1'b0);
   endtask

   task automatic step(logic c_n, logic o_n, logic w, logic [AW-1:0] wa,
                       logic [DW-1:0] wd, logic r, logic [AW-1:0] ra);
      logic wact, ract, coll, rr, rw, uni, bad;
      string tr, tf;
      @(negedge clk);
      ce_n = c_n; oe_n = o_n; we = w; waddr = wa; wdata = wd; re = r; raddr = ra;
      @(posedge clk);
      wact = w && !c_n;
      ract = r && !c_n;
      coll = wact && ract && (wa == ra);
      rr   = ract && (int'(ra) >= DEPTH);
      rw   = wact && (int'(wa) >= DEPTH);
      uni  = ract && !rr && !coll && !ref_wr[ra];
      bad  = coll || rr || uni;
      if (ract) begin
         exp_q = bad ? POISON : ref_mem[ra];
         exp_v = !bad;
      end
      exp_pulse = coll || rr || rw || uni;
      f_coll |= coll; f_rng |= rr || rw; f_uni |= uni;
      if (wact && !rw) begin
         ref_mem[wa] = wd;
         ref_wr[wa]  = 1'b1;
      end
      if (!ract)     tr = c_n ? "R9" : "R10";
      else if (coll) tr = "R2";
      else if (rr)   tr = "R3";
      else if (uni)  tr = "R5";
      else           tr = "R1";
      tf = rw ? "R4" : "R7";
      #1 check_outputs(tr, tf, c_n, o_n);
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20251));
      for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
      do_reset();
      // R5: unwritten word reads back poisoned
      step(0, 0, 0, 0, 0, 1, 6'd5);
      // R1: fill a few words and read them back
      for (int i = 0; i < 4; i++) step(0, 0, 1, AW'(i), DW'(16'h1100 + i), 0, 0);
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, AW'(i));
      // R2: collision poisons, write still lands
      step(0, 0, 1, 6'd1, 16'h5A5A, 1, 6'd1);
      step(0, 0, 0, 0, 0, 1, 6'd1);
      // R4: out-of-range write ignored; neighbours intact
      step(0, 0, 1, 6'd50, 16'hFFFF, 0, 0);
      step(0, 0, 0, 0, 0, 1, 6'd2);
      // R1/R3: last legal word and first illegal word
      step(0, 0, 1, 6'd47, 16'h4747, 0, 0);
      step(0, 0, 0, 0, 0, 1, 6'd47);
      step(0, 0, 0, 0, 0, 1, 6'd48);
      step(0, 0, 0, 0, 0, 1, 6'd63);
      // R9: chip disabled blocks both ports
      step(1, 0, 1, 6'd3, 16'hDEAD, 1, 6'd0);
      step(0, 0, 0, 0, 0, 1, 6'd3);
      // R8: output enable high releases the bus
      step(0, 1, 0, 0, 0, 1, 6'd0);
      step(0, 0, 0, 0, 0, 0, 0);
      // mixed random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [AW-1:0] wa, ra;
         wa = pick_addr();
         ra = ($urandom_range(0, 5) == 0) ? wa : pick_addr();
         step(($urandom_range(0, 15) == 0), ($urandom_range(0, 7) == 0),
              1'($urandom_range(0, 1)), wa, DW'($urandom), 1'($urandom_range(0, 1)), ra);
      end
      // R7/R11: reset clears sticky flags and the written map
      do_reset();
      step(0, 0, 0, 0, 0, 1, 6'd0);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule